// File: doc/BRIEF.md
# Split-Access 64-Bit Counter Register Bank

This block holds a set of 64-bit registers that software reaches through a 32-bit register port. Seven of the registers are free-running event counters. Each counter advances by an increment value on any cycle its strobe is high. The eighth register is a 64-bit scratch register that software can write. Every register takes two consecutive 32-bit word addresses, so software needs two bus accesses to move a full 64-bit value.

Writes to the scratch register are two-phase. A write to the lower-address word only loads a staging word. The following write to the higher-address word commits all 64 bits in one cycle. Reads are made coherent by a single shared shadow word. The first read of either half returns the live half and captures the other half from the same cycle. The later read of that other half returns the captured copy, so a counter that carries between the two accesses still gives a consistent 64-bit value.

A parameter selects the word order. In the default order the most-significant word sits at the lower address. With the parameter cleared, the least-significant word sits at the lower address.

Top module: `split64_regbank`

## Requirements
- R1: After reset all counters, the scratch register and the staging word are zero, the shadow is empty, and `rsp_valid_o` is low.
- R2: Register k sits at byte offset 8·k. Its word at +0 is the lower address and its word at +4 is the higher address. Registers 0 to 6 are the counters, in this order: dequeued requests, encrypt requests, decrypt requests, bytes encrypted, bytes protected, bytes decrypted, bytes validated. Register 7 (offset 0x38) is the scratch register.
- R3: With `MSW_AT_LOW`=1, bits 63:32 are at +0 and bits 31:0 are at +4. With `MSW_AT_LOW`=0, the two words trade places.
- R4: In any cycle where counter k's strobe `cnt_inc_i[k]` is high, the counter adds the unsigned 32-bit field `cnt_amt_i[32k+31:32k]`, wrapping modulo 2^64. Without the strobe it holds its value.
- R5: A write to the scratch register's lower-address word loads only the staging word. The scratch register keeps its value.
- R6: A write to the scratch register's higher-address word commits the staging word and the write data together in one cycle, then clears the staging word. A higher-address write with nothing staged therefore commits zero in the other word.
- R7: Writes to counter addresses, unmapped addresses or misaligned addresses change no register.
- R8: `req_ready_o` is always high. A read accepted at a clock edge gives `rsp_valid_o` high with its data for exactly the following cycle. Writes produce no response.
- R9: If a read does not match the shadow, it returns the live half and captures the other half of the same register from the same cycle. A read that does match the shadow returns the captured word and empties the shadow. A match means the same register and the half the shadow holds.
- R10: Reads of unmapped addresses (at or above 0x40) or misaligned addresses (`req_addr_i[1:0]`≠0) return zero and leave the shadow untouched.
- R11: A mapped read that misses the shadow replaces its contents. This covers a read of a different register and a repeated read of the same half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready, held high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (12) | Byte address |
| req_wdata_i | input | 32 | Write data |
| cnt_inc_i | input | N_CNT (7) | Per-counter increment strobe |
| cnt_amt_i | input | N_CNT*AMT_W (224) | Per-counter increment value, counter k in field k |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The hardest case to reach is a carry from bit 31 into bit 32 of a counter that lands between the two halves of one split read. Only there does a torn value differ from a coherent one. The stimulus drives a byte counter up by 0xFFFFFFFF every cycle while it reads the two halves in both orders, and the bench compares the reads against a model that captures the shadow at the moment the first half is read. Both word orders are instantiated side by side under the same traffic. Random traffic mixes reads that break a half-read pair, reads of unmapped addresses and stray writes to counter addresses, so the bench sees the shadow replaced, kept and consumed.

// File: rtl/split64_pkg.sv
package split64_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 64;

  typedef logic [REG_W-1:0]  reg64_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pick_half(reg64_t v, logic msw);
    return msw ? v[63:32] : v[31:0];
  endfunction
endpackage

// File: rtl/split64_ctr.sv
module split64_ctr
  import split64_pkg::*;
#(
  parameter int AMT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [AMT_W-1:0] amt_i,
  output reg64_t           val_o
);
  reg64_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + REG_W'(amt_i);
  end

  assign val_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R4
  AST_CNT_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q - $past(cnt_q)) == REG_W'($past(amt_i))); // R4
endmodule

// File: rtl/split64_wstage.sv
module split64_wstage
  import split64_pkg::*;
#(
  parameter bit MSW_AT_LOW = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   stage_we_i,
  input  logic   commit_i,
  input  word_t  wdata_i,
  output reg64_t val_o
);
  word_t  stage_q;
  reg64_t scr_q;
  reg64_t commit_val;

  // higher-address word arrives with the commit
  generate
    if (MSW_AT_LOW) begin : g_msw_low
      assign commit_val = {stage_q, wdata_i};
    end else begin : g_lsw_low
      assign commit_val = {wdata_i, stage_q};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      scr_q   <= '0;
    end else if (commit_i) begin
      scr_q   <= commit_val;
      stage_q <= '0;
    end else if (stage_we_i) begin
      stage_q <= wdata_i;
    end
  end

  assign val_o = scr_q;

  AST_STAGE_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_we_i && !commit_i) |=> $stable(scr_q)); // R5
  AST_COMMIT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> pick_half(scr_q, !MSW_AT_LOW) == $past(wdata_i)); // R6
  AST_STAGE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> stage_q == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stage_we_i && !commit_i) |=> $stable(scr_q) && $stable(stage_q)); // R7
endmodule

// File: rtl/split64_rshadow.sv
module split64_rshadow
  import split64_pkg::*;
#(
  parameter int N_REG = 8,
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             mapped_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             msw_i,
  input  reg64_t           vals_i [N_REG],
  output logic             rsp_valid_o,
  output word_t            rsp_rdata_o
);
  logic             shd_vld_q;
  logic [IDX_W-1:0] shd_idx_q;
  logic             shd_msw_q;
  word_t            shd_q;
  logic             rsp_valid_q;
  word_t            rsp_data_q;

  reg64_t live;
  logic   hit;
  word_t  rd_data_d;

  always_comb begin
    live = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (idx_i == IDX_W'(r)) live = vals_i[r];
    end
  end

  assign hit = shd_vld_q && (shd_idx_q == idx_i) && (shd_msw_q == msw_i);

  always_comb begin
    if (!mapped_i)  rd_data_d = '0;
    else if (hit)   rd_data_d = shd_q;
    else            rd_data_d = pick_half(live, msw_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_vld_q   <= 1'b0;
      shd_idx_q   <= '0;
      shd_msw_q   <= 1'b0;
      shd_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_i;
      if (rd_i) begin
        rsp_data_q <= rd_data_d;
        if (mapped_i) begin
          if (hit) begin
            shd_vld_q <= 1'b0;
          end else begin
            shd_vld_q <= 1'b1;
            shd_idx_q <= idx_i;
            shd_msw_q <= ~msw_i;
            shd_q     <= pick_half(live, ~msw_i);
          end
        end
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  AST_SHADOW_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mapped_i && hit) |=> !shd_vld_q); // R9
  AST_SHADOW_FILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mapped_i && !hit) |=> shd_vld_q && (shd_msw_q != $past(msw_i))); // R11
  AST_SHADOW_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || !mapped_i) |=> $stable(shd_vld_q) && $stable(shd_q) && $stable(shd_idx_q)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped_i) |=> rsp_rdata_o == '0); // R10
endmodule

// File: rtl/split64_regbank.sv
module split64_regbank
  import split64_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int N_CNT      = 7,
  parameter int AMT_W      = 32,
  parameter bit MSW_AT_LOW = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [31:0]            req_wdata_i,
  input  logic [N_CNT-1:0]       cnt_inc_i,
  input  logic [N_CNT*AMT_W-1:0] cnt_amt_i,
  output logic                   rsp_valid_o,
  output logic [31:0]            rsp_rdata_o
);
  localparam int N_REG   = N_CNT + 1;
  localparam int IDX_W   = ADDR_W - 3;
  localparam int SCR_IDX = N_CNT;

  logic [IDX_W-1:0] idx;
  logic             upper_addr;
  logic             aligned;
  logic             mapped;
  logic             msw;
  logic             rd_req;
  logic             wr_scr;
  reg64_t           vals [N_REG];

  assign idx        = req_addr_i[ADDR_W-1:3];
  assign upper_addr = req_addr_i[2];
  assign aligned    = (req_addr_i[1:0] == 2'b00);
  assign mapped     = aligned && (idx < IDX_W'(N_REG));
  assign msw        = MSW_AT_LOW ? ~upper_addr : upper_addr;
  assign rd_req     = req_valid_i && !req_write_i;
  assign wr_scr     = req_valid_i && req_write_i && aligned && (idx == IDX_W'(SCR_IDX));

  assign req_ready_o = 1'b1;

  generate
    for (genvar k = 0; k < N_CNT; k++) begin : g_ctr
      split64_ctr #(.AMT_W(AMT_W)) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (cnt_inc_i[k]),
        .amt_i  (cnt_amt_i[k*AMT_W +: AMT_W]),
        .val_o  (vals[k])
      );
    end
  endgenerate

  split64_wstage #(.MSW_AT_LOW(MSW_AT_LOW)) u_wstage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stage_we_i (wr_scr && !upper_addr),
    .commit_i   (wr_scr && upper_addr),
    .wdata_i    (req_wdata_i),
    .val_o      (vals[SCR_IDX])
  );

  split64_rshadow #(.N_REG(N_REG), .IDX_W(IDX_W)) u_rshadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_req),
    .mapped_i    (mapped),
    .idx_i       (idx),
    .msw_i       (msw),
    .vals_i      (vals),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(rd_req)); // R8
  AST_READY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o); // R8
  AST_CTR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !cnt_inc_i[0]) |=> $stable(vals[0])); // R7
endmodule

// File: tb/tb_split64_regbank.sv
`timescale 1ns/1ps
module tb_split64_regbank;
  localparam int NC = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [NC-1:0] cnt_inc = '0;
  logic [NC*32-1:0] cnt_amt = '0;

  logic        rdy_a, rdy_b, vld_a, vld_b;
  logic [31:0] dat_a, dat_b;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  split64_regbank #(.MSW_AT_LOW(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy_a),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cnt_inc_i(cnt_inc), .cnt_amt_i(cnt_amt), .rsp_valid_o(vld_a), .rsp_rdata_o(dat_a));

  split64_regbank #(.MSW_AT_LOW(1'b0)) dut_lsw (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy_b),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cnt_inc_i(cnt_inc), .cnt_amt_i(cnt_amt), .rsp_valid_o(vld_b), .rsp_rdata_o(dat_b));

  // reference model; instance 0 = MSW at lower address, 1 = LSW at lower address
  logic [63:0] m_cnt [NC];
  logic [63:0] m_scr [2];
  logic [31:0] m_stg [2];
  logic        m_sv  [2];
  int          m_sidx[2];
  logic        m_smsw[2];
  logic [31:0] m_shd [2];

  function automatic logic msw_of(int inst, logic upper);
    return (inst == 0) ? !upper : upper;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input bit w, input logic [11:0] a, input logic [31:0] d,
                       input logic [NC-1:0] inc, input logic [NC*32-1:0] amt, input string tag);
    logic [31:0] e [2];
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    cnt_inc = inc; cnt_amt = amt;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      int idx;
      logic up, ms, ok;
      logic [63:0] val;
      e[i] = '0;
      idx = int'(a[11:3]);
      up  = a[2];
      ms  = msw_of(i, up);
      ok  = (a[1:0] == 2'b00) && (idx < NC + 1);
      if (v && !w && ok) begin
        val = (idx < NC) ? m_cnt[idx] : m_scr[i];
        if (m_sv[i] && m_sidx[i] == idx && m_smsw[i] == ms) begin
          e[i] = m_shd[i];
          m_sv[i] = 1'b0;
        end else begin
          e[i] = ms ? val[63:32] : val[31:0];
          m_sv[i] = 1'b1; m_sidx[i] = idx; m_smsw[i] = !ms;
          m_shd[i] = ms ? val[31:0] : val[63:32];
        end
      end
      if (v && w && (a[1:0] == 2'b00) && idx == NC) begin
        if (!up) m_stg[i] = d;
        else begin
          m_scr[i] = (i == 0) ? {m_stg[i], d} : {d, m_stg[i]};
          m_stg[i] = '0;
        end
      end
    end
    for (int k = 0; k < NC; k++)
      if (inc[k]) m_cnt[k] = m_cnt[k] + 64'(amt[k*32 +: 32]);
    #1;
    if (v && !w) begin
      chk({tag, " R8 valid a"}, 32'(vld_a), 32'd1);
      chk({tag, " R8 valid b"}, 32'(vld_b), 32'd1);
      chk({tag, " data msw-low"}, dat_a, e[0]);
      chk({tag, " data lsw-low"}, dat_b, e[1]);
    end else begin
      chk({tag, " R8 no rsp a"}, 32'(vld_a), 32'd0);
      chk({tag, " R8 no rsp b"}, 32'(vld_b), 32'd0);
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cycle(1'b1, 1'b0, a, '0, '0, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cycle(1'b1, 1'b1, a, d, '0, '0, tag);
  endtask

  function automatic logic [NC*32-1:0] one_amt(int k, logic [31:0] v);
    logic [NC*32-1:0] r = '0;
    r[k*32 +: 32] = v;
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NC*32-1:0] amt;
    for (int k = 0; k < NC; k++) m_cnt[k] = '0;
    for (int i = 0; i < 2; i++) begin
      m_scr[i] = '0; m_stg[i] = '0; m_sv[i] = 1'b0; m_sidx[i] = 0; m_smsw[i] = 1'b0; m_shd[i] = '0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 rsp low in reset", 32'(vld_a | vld_b), 32'd0);
    rst_n = 1'b1;
    chk("R8 ready", 32'(rdy_a & rdy_b), 32'd1);

    // R1: everything reads zero
    for (int r = 0; r < 8; r++) begin
      rd(12'(r * 8), "R1");
      rd(12'(r * 8 + 4), "R1");
    end

    // R4: request counter steps by one
    repeat (5) cycle(1'b0, 1'b0, '0, '0, 7'b0000001, one_amt(0, 32'd1), "R4");
    rd(12'h000, "R4"); rd(12'h004, "R4");

    // R9: carry between halves during split reads, both orders
    amt = one_amt(3, 32'hFFFF_FFFF);
    cycle(1'b1, 1'b0, 12'h018, '0, 7'b0001000, amt, "R9");
    cycle(1'b0, 1'b0, '0, '0, 7'b0001000, amt, "R9");
    cycle(1'b1, 1'b0, 12'h01C, '0, 7'b0001000, amt, "R9");
    cycle(1'b1, 1'b0, 12'h01C, '0, 7'b0001000, amt, "R9");
    cycle(1'b1, 1'b0, 12'h018, '0, 7'b0001000, amt, "R9");

    // R11: repeated same half recaptures; other register replaces shadow
    cycle(1'b1, 1'b0, 12'h018, '0, 7'b0001000, amt, "R11");
    cycle(1'b1, 1'b0, 12'h018, '0, 7'b0001000, amt, "R11");
    rd(12'h000, "R11");
    rd(12'h01C, "R11");

    // R10: unmapped and misaligned reads leave shadow intact
    rd(12'h018, "R10");
    rd(12'h100, "R10");
    rd(12'h019, "R10");
    rd(12'h01C, "R10");

    // R5/R6/R3: scratch staging and commit
    wr(12'h038, 32'hA5A5_0001, "R5");
    rd(12'h038, "R5"); rd(12'h03C, "R5");
    wr(12'h03C, 32'h5A5A_0002, "R6");
    rd(12'h038, "R3"); rd(12'h03C, "R3");
    wr(12'h03C, 32'h1234_5678, "R6");
    rd(12'h03C, "R6"); rd(12'h038, "R6");

    // R7: stray writes
    wr(12'h000, 32'hDEAD_BEEF, "R7");
    wr(12'h004, 32'hDEAD_BEEF, "R7");
    wr(12'h200, 32'hDEAD_BEEF, "R7");
    wr(12'h03A, 32'hDEAD_BEEF, "R7");
    rd(12'h000, "R7"); rd(12'h004, "R7");
    rd(12'h038, "R7"); rd(12'h03C, "R7");

    // R2: each counter on its own offset
    for (int k = 0; k < NC; k++)
      cycle(1'b0, 1'b0, '0, '0, 7'(1 << k), one_amt(k, 32'(k + 1) * 32'h0101), "R2");
    for (int k = 0; k < NC; k++) begin
      rd(12'(k * 8), "R2");
      rd(12'(k * 8 + 4), "R2");
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic v, w;
      logic [11:0] a;
      logic [NC-1:0] inc;
      int r;
      v = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 9);
      if (w && $urandom_range(0, 2) != 0) r = 7;
      a = {(r == 9) ? 9'($urandom_range(0, 7)) : 9'(r), 1'($urandom_range(0, 1)), 2'b00};
      if (r == 9) a[0] = 1'b1;
      inc = 7'($urandom);
      for (int k = 0; k < NC; k++)
        amt[k*32 +: 32] = ($urandom_range(0, 1) != 0) ? $urandom : 32'($urandom_range(0, 3));
      cycle(v, w, a, $urandom, inc, amt, "R9 rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule